// File: doc/BRIEF.md
# Blinking GPIO Port

This block is a parallel general-purpose I/O port of `PINS` pins (32 by default) behind a word-wide register port. Software picks, for each pin, whether it is an input or an output, which level an output drives, whether an output blinks, and whether its input is read inverted. A read-only word gives the input pins after a two-flop synchronizer and the per-pin inversion. The pad tristate drivers sit outside the block; it gives them a per-pin output value and an output-enable.

A single free-running timer flips one shared blink phase every `BLINK_HALF_CYC` clock cycles, so on and off times are equal. While a pin's blink bit is set, that pin shows the phase and its output register bit has no effect on it. All blinking pins therefore move together. Software is expected to clear the output bit before it starts blinking and to clear the blink bit before it drives a fixed level. The register port is a plain synchronous strobe with no back-pressure. A write takes effect on the clock edge that samples it. Read data is combinational in the same cycle. Interrupt generation lives in a separate block.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset the direction word reads all ones (every pin an input, `pin_oe` all zero). The output, blink and polarity words read zero, and `pin_out` is zero.
- R2: A write to byte offset 0x00 (output level), 0x04 (direction), 0x08 (blink enable) or 0x0C (input polarity) stores the whole word. A read of the same offset returns it.
- R3: Direction bit i equal to 1 makes pin i an input (`pin_oe[i]`=0). A 0 makes it an output (`pin_oe[i]`=1). This takes effect from the edge that takes the write.
- R4: A pin whose blink bit is clear drives its output register bit on `pin_out`.
- R5: A read of offset 0x10 returns the pin inputs XOR the polarity word. A change on `pin_in` shows up in this read only after the second rising edge, because of the two-flop synchronizer.
- R6: Offset 0x10 is read-only. A write to it changes no register and does not change the value read there.
- R7: A pin whose blink bit is set shows the shared blink phase, whatever its output register bit holds. All blinking pins carry the same value in every cycle.
- R8: The blink phase is low after reset. It first goes high after `BLINK_HALF_CYC` rising edges, and it then toggles every `BLINK_HALF_CYC` edges.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero. This includes offsets that are not word aligned. A write to such an offset changes nothing.
- R10: When the blink bit of a pin is cleared, the pin drives its output register bit again from the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational, zero when not reading |
| pin_in | input | PINS | Raw pad input levels |
| pin_out | output | PINS | Level to drive on each pad |
| pin_oe | output | PINS | Pad output enable, 1 = drive |

## Verification
The bench reads the input word one edge and two edges after a pin change. A design with a single synchronizer stage, or with none, shows the new value one edge too early. It measures the blink phase from the edge where reset is released and between toggles, so an off-by-one terminal count or a phase that starts high shows up as a wrong level at a counted cycle. It drives a blinking pin's output register bit opposite to a second blinking pin and checks that both stay equal, which catches an output mux that ORs the register in. Writes to the read-only and unmapped offsets are followed by full read-back, so a decoder that aliases an address corrupts a visible register.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_BLINK = 32'h08;
  localparam int unsigned OFS_INV   = 32'h0C;
  localparam int unsigned OFS_SENSE = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DIR,
    SEL_BLINK,
    SEL_INV,
    SEL_SENSE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_LEVEL: s = SEL_LEVEL;
      OFS_DIR:   s = SEL_DIR;
      OFS_BLINK: s = SEL_BLINK;
      OFS_INV:   s = SEL_INV;
      OFS_SENSE: s = SEL_SENSE;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_async;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int unsigned HALF_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);

  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      phase  <= 1'b0;
    end else if (tick_q == LAST) begin
      tick_q <= '0;
      phase  <= ~phase;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_blink_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   sense_word,
  output logic [PINS-1:0]   level_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   blink_q,
  output logic [PINS-1:0]   inv_q
);

  reg_sel_e sel;
  logic     wr;

  assign sel = decode_offset(32'(bus_addr));
  assign wr  = bus_en && bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      inv_q   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_LEVEL: level_q <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_BLINK: blink_q <= bus_wdata;
        SEL_INV:   inv_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (sel)
        SEL_LEVEL: bus_rdata = level_q;
        SEL_DIR:   bus_rdata = dir_q;
        SEL_BLINK: bus_rdata = blink_q;
        SEL_INV:   bus_rdata = inv_q;
        SEL_SENSE: bus_rdata = sense_word;
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port #(
  parameter int unsigned PINS           = 32,
  parameter int unsigned ADDR_W         = 5,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned BLINK_HALF_CYC = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  logic [PINS-1:0] level_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] blink_q;
  logic [PINS-1:0] inv_q;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] sense_word;
  logic            blink_phase;

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  gpio_blink_timer #(.HALF_CYC(BLINK_HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (blink_phase)
  );

  assign sense_word = pin_sync ^ inv_q;

  gpio_reg_bank #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .sense_word (sense_word),
    .level_q    (level_q),
    .dir_q      (dir_q),
    .blink_q    (blink_q),
    .inv_q      (inv_q)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pin_out[i] = blink_q[i] ? blink_phase : level_q[i];
    assign pin_oe[i]  = ~dir_q[i];
  end

endmodule

// File: rtl/gpio_blink_port_chk.sv
module gpio_blink_port_chk
  import gpio_blink_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned HALF   = 20_000_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   blink_q,
  input logic              phase
);

  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] run_cnt;
  logic          unmapped;
  logic [PINS-1:0] blink_vis;

  assign unmapped  = (decode_offset(32'(bus_addr)) == SEL_NONE);
  assign blink_vis = pin_out & blink_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              run_cnt <= '0;
    else if (run_cnt == LAST) run_cnt <= '0;
    else                     run_cnt <= run_cnt + 1'b1;
  end

  // R1
  a_r1_reset_pins: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> pin_oe == ~$past(bus_wdata));

  a_r4_level_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFS_LEVEL))
      |=> ((pin_out ^ $past(bus_wdata)) & ~blink_q) == '0);

  a_r7_shared_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_vis == '0) || (blink_vis == blink_q));

  a_r8_toggle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == LAST) |=> !$stable(phase));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt != LAST) |=> $stable(phase));

  a_r9_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && unmapped) |-> bus_rdata == '0);

  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && unmapped) |=> ($stable(pin_oe) && $stable(blink_q)));

endmodule

bind gpio_blink_port gpio_blink_port_chk #(
  .PINS(PINS), .ADDR_W(ADDR_W), .HALF(BLINK_HALF_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .blink_q   (blink_q),
  .phase     (blink_phase)
);

// File: tb/gpio_blink_port_bench.sv
`timescale 1ns/1ps
module gpio_blink_port_bench;

  localparam int unsigned PINS = 32;
  localparam int unsigned AW   = 5;
  localparam int unsigned HALF = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_en = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_blink_port #(.PINS(PINS), .ADDR_W(AW), .BLINK_HALF_CYC(HALF)) u_gpio_blink_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    #1;
    cmp("R1 pin_oe", pin_oe, 32'h0);
    cmp("R1 pin_out", pin_out, 32'h0);
    rd(5'h00, d); cmp("R1 level", d, 32'h0);
    rd(5'h04, d); cmp("R1 dir", d, 32'hFFFF_FFFF);
    rd(5'h08, d); cmp("R1 blink", d, 32'h0);
    rd(5'h0C, d); cmp("R1 inv", d, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(5'h00, 32'h1234_5678); rd(5'h00, d); cmp("R2 level", d, 32'h1234_5678);
    wr(5'h04, 32'h0F0F_00FF); rd(5'h04, d); cmp("R2 dir", d, 32'h0F0F_00FF);
    wr(5'h08, 32'h8000_0001); rd(5'h08, d); cmp("R2 blink", d, 32'h8000_0001);
    wr(5'h0C, 32'hDEAD_BEEF); rd(5'h0C, d); cmp("R2 inv", d, 32'hDEAD_BEEF);
    wr(5'h08, 32'h0);         rd(5'h08, d); cmp("R2 blink clr", d, 32'h0);
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_drive();
    wr(5'h04, 32'hFFFF_0000);
    #1 cmp("R3 oe", pin_oe, 32'h0000_FFFF);
    wr(5'h00, 32'hA5A5_C3C3);
    #1 cmp("R4 out", pin_out, 32'hA5A5_C3C3);
    wr(5'h04, 32'h0000_0000);
    #1 cmp("R3 all out", pin_oe, 32'hFFFF_FFFF);
  endtask

  task automatic t_sense();
    logic [31:0] d;
    wr(5'h0C, 32'h0000_FF00);
    pin_in = 32'h1111_1111;
    repeat (3) @(negedge clk);
    rd(5'h10, d); cmp("R5 sense", d, 32'h1111_EE11);
    pin_in = 32'h8000_0F0F;
    rd(5'h10, d); cmp("R5 after one edge", d, 32'h1111_EE11);
    rd(5'h10, d); cmp("R5 after two edges", d, 32'h8000_F00F);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d); cmp("R6 sense unchanged", d, 32'h8000_F00F);
    rd(5'h00, d); cmp("R6 level kept", d, 32'hA5A5_C3C3);
    rd(5'h04, d); cmp("R6 dir kept", d, 32'h0);
    rd(5'h08, d); cmp("R6 blink kept", d, 32'h0);
    rd(5'h0C, d); cmp("R6 inv kept", d, 32'h0000_FF00);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(5'h14, d); cmp("R9 rd 0x14", d, 32'h0);
    rd(5'h1C, d); cmp("R9 rd 0x1C", d, 32'h0);
    rd(5'h02, d); cmp("R9 rd 0x02", d, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h05, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(5'h00, d); cmp("R9 level kept", d, 32'hA5A5_C3C3);
    rd(5'h04, d); cmp("R9 dir kept", d, 32'h0);
    rd(5'h08, d); cmp("R9 blink kept", d, 32'h0);
    rd(5'h0C, d); cmp("R9 inv kept", d, 32'h0000_FF00);
    #1 cmp("R9 pins kept", pin_out, 32'hA5A5_C3C3);
  endtask

  task automatic t_blink_run();
    int since;
    int seen;
    logic prev;
    wr(5'h00, 32'h0000_0008);
    wr(5'h08, 32'h0002_0008);
    prev  = pin_out[3];
    since = 0;
    seen  = 0;
    for (int k = 0; k < 5 * HALF; k++) begin
      @(negedge clk);
      #1;
      since++;
      if (pin_out[3] !== pin_out[17]) cmp("R7 shared", {31'b0, pin_out[17]}, {31'b0, pin_out[3]});
      if (pin_out[3] !== prev) begin
        if (seen > 0) cmp("R8 half period", since, HALF);
        seen++;
        since = 0;
        prev  = pin_out[3];
      end
    end
    cmp("R8 toggles seen", (seen >= 4) ? 1 : 0, 1);
    cmp("R7 others follow level", pin_out & ~32'h0002_0008, 32'h0);
    wr(5'h08, 32'h0002_0000);
    #1 cmp("R10 unblink level", {31'b0, pin_out[3]}, 32'h1);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_blink_start();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h0000_0010;
    for (int k = 1; k <= 3 * HALF; k++) begin
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      #1 cmp($sformatf("R8 start edge %0d", k), {31'b0, pin_out[4]}, 32'((k / HALF) % 2));
    end
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_readback();
    t_drive();
    t_sense();
    t_unmapped();
    t_blink_run();
    t_blink_start();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule